// File: doc/BRIEF.md
# Zero-Extending Load Address Unit with Base Update

This block sits in the load path of an integer pipeline. It takes one decoded byte or halfword load at a time: the primary and extended opcode fields, three register indices, the two source register values and a 16-bit displacement. From these it forms the effective address (EA), issues a single read on a simple memory port and waits for the data to come back.

When the data arrives, the block zero-extends the byte or halfword into a target-register write. For the update forms it also writes the EA back into the base register in that same cycle. An update form whose base index is zero, or equals the target index, is rejected: the block raises a one-cycle illegal-form pulse and makes no memory access.

A mode input limits the EA to its low 32 bits for 32-bit operation.

Top module: `lsu_load_agen`

## Requirements
- R1: Only these opcodes are accepted. Primary 34 is a byte load with displacement and 35 is its update form. Primary 40 is a halfword load with displacement and 41 is its update form. Primary 31 selects an indexed form through the extended opcode: 87 is a byte load, 119 a byte load with update, 279 a halfword load and 311 a halfword load with update. Any other code produces no request, no write and no illegal pulse.
- R2: For the forms without update, a base index of 0 gives a base of zero, whatever `ra_value` holds. Any other index uses `ra_value`.
- R3: Displacement forms compute EA = base + sign-extended `issue_disp`. Indexed forms compute EA = base + `rb_value`. The sum wraps at XLEN bits.
- R4: One cycle after an accepted issue, `mem_req` is high for exactly one cycle. In that cycle `mem_addr` carries the EA and `mem_size` is 0 for a byte or 1 for a halfword.
- R5: In the cycle that `mem_rvalid` is seen after a request, `rt_we` is high and `rt_wr_idx` equals the issued target index. For a byte, `rt_wr_data` is `mem_rdata[7:0]` zero-extended. For a halfword, `rt_wr_data` is `mem_rdata[15:0]` zero-extended, where `mem_rdata[15:8]` is the byte at the lower address.
- R6: Update forms take `ra_value` as the base. In the same cycle as `rt_we`, they assert `ra_we` with `ra_wr_idx` equal to the base index and `ra_wr_data` equal to the EA. Forms without update never assert `ra_we`.
- R7: An update form with a base index of 0, or with the base index equal to the target index, pulses `illegal_op` for one cycle, one cycle after issue. It produces no `mem_req`, no `rt_we` and no `ra_we`, and `busy` stays low.
- R8: With `mode32` high at issue, bits XLEN-1..32 of the EA are zero. With `mode32` low, the full XLEN-bit sum is used.
- R9: `busy` is high from the cycle after an accepted load until the data-return cycle. Issues presented while `busy` is high are ignored, and `mem_addr` holds its value.
- R10: After reset, `busy`, `mem_req`, `rt_we`, `ra_we` and `illegal_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A decoded instruction is presented |
| issue_prim | input | 6 | Primary opcode |
| issue_ext | input | 10 | Extended opcode (used with primary 31) |
| issue_ra | input | 5 | Base register index |
| issue_rb | input | 5 | Index register index |
| issue_rt | input | 5 | Target register index |
| ra_value | input | XLEN | Base register contents |
| rb_value | input | XLEN | Index register contents |
| issue_disp | input | 16 | Signed displacement |
| mode32 | input | 1 | Limit EA to 32 bits |
| busy | output | 1 | A load is outstanding |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | XLEN | Read address |
| mem_size | output | 1 | 0 byte, 1 halfword |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, lower-address byte in bits 15:8 |
| rt_we | output | 1 | Target register write enable |
| rt_wr_idx | output | 5 | Target register write index |
| rt_wr_data | output | XLEN | Zero-extended load result |
| ra_we | output | 1 | Base register write enable |
| ra_wr_idx | output | 5 | Base register write index |
| ra_wr_data | output | XLEN | EA written back to the base register |
| illegal_op | output | 1 | Illegal update form pulse |

## Verification
The assertions check the cycle-level rules on every cycle:
- the request is a single-cycle pulse and appears only while busy;
- target writes happen only on a data return, and base writes only together with a target write;
- an illegal pulse never coincides with a request or a write;
- a request issued in 32-bit mode has a clean upper address half.

Only the directed scenarios can show the values themselves: the opcode decode, the zero base for index 0, sign extension of the displacement, big-endian halfword assembly and the EA written back to the base register. The same holds for the two rules that concern inputs being ignored: unknown opcodes, and issues presented while busy.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int REG_IDX_W = 5;
  localparam int DISP_W    = 16;
  localparam int MEM_DW    = 16;
  localparam int PRIM_W    = 6;
  localparam int EXT_W     = 10;

  localparam logic [PRIM_W-1:0] OP_BYTE_D    = 6'd34;
  localparam logic [PRIM_W-1:0] OP_BYTE_DU   = 6'd35;
  localparam logic [PRIM_W-1:0] OP_HALF_D    = 6'd40;
  localparam logic [PRIM_W-1:0] OP_HALF_DU   = 6'd41;
  localparam logic [PRIM_W-1:0] OP_EXTENDED  = 6'd31;
  localparam logic [EXT_W-1:0]  XO_BYTE_X    = 10'd87;
  localparam logic [EXT_W-1:0]  XO_BYTE_XU   = 10'd119;
  localparam logic [EXT_W-1:0]  XO_HALF_X    = 10'd279;
  localparam logic [EXT_W-1:0]  XO_HALF_XU   = 10'd311;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lsu_state_e;

  typedef struct packed {
    logic valid;
    logic half;
    logic update;
    logic indexed;
  } ld_kind_t;
endpackage

// File: rtl/lsu_ld_decode.sv
module lsu_ld_decode
  import lsu_pkg::*;
(
  input  logic [PRIM_W-1:0]    prim,
  input  logic [EXT_W-1:0]     ext,
  input  logic [REG_IDX_W-1:0] ra,
  input  logic [REG_IDX_W-1:0] rt,
  output ld_kind_t             kind,
  output logic                 bad_form
);
  always_comb begin
    kind = '0;
    unique case (prim)
      OP_BYTE_D:  kind = '{valid: 1'b1, half: 1'b0, update: 1'b0, indexed: 1'b0};
      OP_BYTE_DU: kind = '{valid: 1'b1, half: 1'b0, update: 1'b1, indexed: 1'b0};
      OP_HALF_D:  kind = '{valid: 1'b1, half: 1'b1, update: 1'b0, indexed: 1'b0};
      OP_HALF_DU: kind = '{valid: 1'b1, half: 1'b1, update: 1'b1, indexed: 1'b0};
      OP_EXTENDED: begin
        unique case (ext)
          XO_BYTE_X:  kind = '{valid: 1'b1, half: 1'b0, update: 1'b0, indexed: 1'b1};
          XO_BYTE_XU: kind = '{valid: 1'b1, half: 1'b0, update: 1'b1, indexed: 1'b1};
          XO_HALF_X:  kind = '{valid: 1'b1, half: 1'b1, update: 1'b0, indexed: 1'b1};
          XO_HALF_XU: kind = '{valid: 1'b1, half: 1'b1, update: 1'b1, indexed: 1'b1};
          default:    kind = '0;
        endcase
      end
      default: kind = '0;
    endcase
  end

  // update form must name a real base register distinct from the target
  assign bad_form = kind.valid && kind.update && ((ra == '0) || (ra == rt));
endmodule

// File: rtl/lsu_ld_agen.sv
module lsu_ld_agen
  import lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              base_is_zero,
  input  logic              indexed,
  input  logic              update,
  input  logic [XLEN-1:0]   ra_value,
  input  logic [XLEN-1:0]   rb_value,
  input  logic [DISP_W-1:0] disp,
  input  logic              mode32,
  output logic [XLEN-1:0]   ea
);
  localparam int EXT_BITS = XLEN - DISP_W;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] sum;

  assign base   = (base_is_zero && !update) ? '0 : ra_value;
  assign offset = indexed ? rb_value : {{EXT_BITS{disp[DISP_W-1]}}, disp};
  assign sum    = base + offset;

  generate
    if (XLEN > 32) begin : g_wide
      assign ea = mode32 ? {{(XLEN-32){1'b0}}, sum[31:0]} : sum;
    end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = mode32;
      assign ea = sum;
    end
  endgenerate
endmodule

// File: rtl/lsu_ld_extend.sv
module lsu_ld_extend
  import lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              half,
  input  logic [MEM_DW-1:0] rdata,
  output logic [XLEN-1:0]   result
);
  // rdata[15:8] holds the lower-address byte, so a halfword is already in order
  assign result = half ? {{(XLEN-16){1'b0}}, rdata}
                       : {{(XLEN-8){1'b0}}, rdata[7:0]};
endmodule

// File: rtl/lsu_load_agen.sv
module lsu_load_agen
  import lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [5:0]           issue_prim,
  input  logic [9:0]           issue_ext,
  input  logic [4:0]           issue_ra,
  input  logic [4:0]           issue_rb,
  input  logic [4:0]           issue_rt,
  input  logic [XLEN-1:0]      ra_value,
  input  logic [XLEN-1:0]      rb_value,
  input  logic [15:0]          issue_disp,
  input  logic                 mode32,
  output logic                 busy,
  output logic                 mem_req,
  output logic [XLEN-1:0]      mem_addr,
  output logic                 mem_size,
  input  logic                 mem_rvalid,
  input  logic [15:0]          mem_rdata,
  output logic                 rt_we,
  output logic [4:0]           rt_wr_idx,
  output logic [XLEN-1:0]      rt_wr_data,
  output logic                 ra_we,
  output logic [4:0]           ra_wr_idx,
  output logic [XLEN-1:0]      ra_wr_data,
  output logic                 illegal_op
);
  lsu_state_e             state_q;
  ld_kind_t               kind;
  logic                   bad_form;
  logic [XLEN-1:0]        ea;
  logic [XLEN-1:0]        ea_q;
  logic                   half_q;
  logic                   upd_q;
  logic [REG_IDX_W-1:0]   rt_q;
  logic [REG_IDX_W-1:0]   ra_q;
  logic                   illegal_q;
  logic                   accept;
  logic                   done;
  logic                   unused_rb;

  assign unused_rb = ^issue_rb;

  lsu_ld_decode u_dec (
    .prim     (issue_prim),
    .ext      (issue_ext),
    .ra       (issue_ra),
    .rt       (issue_rt),
    .kind     (kind),
    .bad_form (bad_form)
  );

  lsu_ld_agen #(.XLEN(XLEN)) u_agen (
    .base_is_zero (issue_ra == '0),
    .indexed      (kind.indexed),
    .update       (kind.update),
    .ra_value     (ra_value),
    .rb_value     (rb_value),
    .disp         (issue_disp),
    .mode32       (mode32),
    .ea           (ea)
  );

  lsu_ld_extend #(.XLEN(XLEN)) u_ext (
    .half   (half_q),
    .rdata  (mem_rdata),
    .result (rt_wr_data)
  );

  assign accept = issue_valid && (state_q == ST_IDLE) && kind.valid && !bad_form;
  assign done   = (state_q == ST_WAIT) && mem_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      half_q    <= 1'b0;
      upd_q     <= 1'b0;
      rt_q      <= '0;
      ra_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= issue_valid && (state_q == ST_IDLE) && bad_form;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_REQ;
          ea_q    <= ea;
          half_q  <= kind.half;
          upd_q   <= kind.update;
          rt_q    <= issue_rt;
          ra_q    <= issue_ra;
        end
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_REQ);
  assign mem_addr   = ea_q;
  assign mem_size   = half_q;
  assign rt_we      = done;
  assign rt_wr_idx  = rt_q;
  assign ra_we      = done && upd_q;
  assign ra_wr_idx  = ra_q;
  assign ra_wr_data = ea_q;
  assign illegal_op = illegal_q;
endmodule

// File: rtl/lsu_load_agen_chk.sv
module lsu_load_agen_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            mem_req,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_rvalid,
  input logic            rt_we,
  input logic            ra_we,
  input logic            illegal_op,
  input logic            mode32
);
  // R4: request lasts a single cycle
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R9: a request only exists while a load is outstanding
  p_req_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R5: target write only on a data return of an outstanding load
  p_wb_on_return_r5: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (busy && mem_rvalid && !mem_req));

  // R6: base write only together with target write
  p_ra_with_rt_r6: assert property (@(posedge clk) disable iff (rst)
    ra_we |-> rt_we);

  // R7: illegal form never accesses memory or writes
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (!mem_req && !rt_we && !ra_we && !busy));

  generate
    if (XLEN > 32) begin : g_m32
      // R8: 32-bit mode request has clean upper half
      p_mode32_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mode32)) |-> (mem_addr[XLEN-1:32] == '0));
    end
  endgenerate
endmodule

bind lsu_load_agen lsu_load_agen_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .rt_we      (rt_we),
  .ra_we      (ra_we),
  .illegal_op (illegal_op),
  .mode32     (mode32)
);

// File: tb/tb_lsu_load_agen.sv
module tb_lsu_load_agen;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            issue_valid = 1'b0;
  logic [5:0]      issue_prim = '0;
  logic [9:0]      issue_ext = '0;
  logic [4:0]      issue_ra = '0, issue_rb = '0, issue_rt = '0;
  logic [XLEN-1:0] ra_value = '0, rb_value = '0;
  logic [15:0]     issue_disp = '0;
  logic            mode32 = 1'b0;
  logic            busy, mem_req, mem_size, mem_rvalid = 1'b0;
  logic [XLEN-1:0] mem_addr, rt_wr_data, ra_wr_data;
  logic [15:0]     mem_rdata = '0;
  logic            rt_we, ra_we, illegal_op;
  logic [4:0]      rt_wr_idx, ra_wr_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsu_load_agen #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_prim(issue_prim),
    .issue_ext(issue_ext), .issue_ra(issue_ra), .issue_rb(issue_rb),
    .issue_rt(issue_rt), .ra_value(ra_value), .rb_value(rb_value),
    .issue_disp(issue_disp), .mode32(mode32), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rt_we(rt_we), .rt_wr_idx(rt_wr_idx),
    .rt_wr_data(rt_wr_data), .ra_we(ra_we), .ra_wr_idx(ra_wr_idx),
    .ra_wr_data(ra_wr_data), .illegal_op(illegal_op)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [63:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction

  task automatic present(input logic [5:0] p, input logic [9:0] x,
                         input logic [4:0] ra, input logic [4:0] rb,
                         input logic [4:0] rt, input logic [63:0] rav,
                         input logic [63:0] rbv, input logic [15:0] d,
                         input bit m32);
    issue_prim = p; issue_ext = x; issue_ra = ra; issue_rb = rb; issue_rt = rt;
    ra_value = rav; rb_value = rbv; issue_disp = d; mode32 = m32;
    issue_valid = 1'b1;
  endtask

  // full legal load: request, delayed return, write-back
  task automatic do_load(input string tag, input logic [5:0] p, input logic [9:0] x,
                         input logic [4:0] ra, input logic [4:0] rb,
                         input logic [4:0] rt, input logic [63:0] rav,
                         input logic [63:0] rbv, input logic [15:0] d,
                         input bit m32, input int lat, input logic [63:0] exp_ea,
                         input bit half, input bit upd);
    logic [15:0] w;
    logic [63:0] exp_rt;
    @(negedge clk);
    present(p, x, ra, rb, rt, rav, rbv, d, m32);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(mem_req == 1'b1, {tag, " R4 req"}, 64'(mem_req), 64'd1);
    chk(mem_addr == exp_ea, {tag, " R3 addr"}, mem_addr, exp_ea);
    chk(mem_size == half, {tag, " R4 size"}, 64'(mem_size), 64'(half));
    chk(busy == 1'b1, {tag, " R9 busy"}, 64'(busy), 64'd1);
    repeat (lat) begin
      @(negedge clk);
      chk(mem_req == 1'b0 && busy == 1'b1 && rt_we == 1'b0,
          {tag, " R4 wait"}, {61'd0, mem_req, busy, rt_we}, 64'd2);
    end
    w = mem_word(exp_ea);
    exp_rt = half ? {48'd0, w} : {56'd0, w[7:0]};
    mem_rdata = w; mem_rvalid = 1'b1;
    #1;
    chk(rt_we == 1'b1 && rt_wr_idx == rt, {tag, " R5 rt write"},
        {58'd0, rt_we, rt_wr_idx}, {58'd0, 1'b1, rt});
    chk(rt_wr_data == exp_rt, {tag, " R5 rt data"}, rt_wr_data, exp_rt);
    chk(ra_we == upd, {tag, " R6 ra we"}, 64'(ra_we), 64'(upd));
    if (upd) chk(ra_wr_idx == ra && ra_wr_data == exp_ea, {tag, " R6 ra data"},
                 ra_wr_data, exp_ea);
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(busy == 1'b0 && rt_we == 1'b0, {tag, " R9 idle"}, {62'd0, busy, rt_we}, 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req && !rt_we && !ra_we && !illegal_op, "R10 reset",
        {59'd0, busy, mem_req, rt_we, ra_we, illegal_op}, 64'd0);
  endtask

  task automatic t_illegal(input string tag, input logic [5:0] p, input logic [9:0] x,
                           input logic [4:0] ra, input logic [4:0] rt);
    @(negedge clk);
    present(p, x, ra, 5'd2, rt, 64'h100, 64'h8, 16'h4, 1'b0);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(illegal_op == 1'b1, {tag, " R7 pulse"}, 64'(illegal_op), 64'd1);
    chk(!mem_req && !busy, {tag, " R7 no access"}, {62'd0, mem_req, busy}, 64'd0);
    repeat (2) begin
      @(negedge clk);
      chk(!illegal_op && !mem_req && !rt_we && !ra_we, {tag, " R7 quiet"},
          {60'd0, illegal_op, mem_req, rt_we, ra_we}, 64'd0);
    end
  endtask

  task automatic t_unknown(input string tag, input logic [5:0] p, input logic [9:0] x);
    @(negedge clk);
    present(p, x, 5'd3, 5'd4, 5'd5, 64'h40, 64'h8, 16'h2, 1'b0);
    @(negedge clk);
    issue_valid = 1'b0;
    repeat (3) begin
      chk(!mem_req && !busy && !illegal_op && !rt_we, {tag, " R1 ignored"},
          {60'd0, mem_req, busy, illegal_op, rt_we}, 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    present(6'd34, 10'd0, 5'd3, 5'd0, 5'd7, 64'h500, 64'd0, 16'h10, 1'b0);
    @(negedge clk);
    chk(mem_addr == 64'h510, "R9 first addr", mem_addr, 64'h510);
    present(6'd40, 10'd0, 5'd3, 5'd0, 5'd8, 64'h900, 64'd0, 16'h20, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk(mem_addr == 64'h510 && !mem_req, "R9 held while busy", mem_addr, 64'h510);
    end
    issue_valid = 1'b0;
    mem_rdata = mem_word(64'h510); mem_rvalid = 1'b1;
    #1;
    chk(rt_wr_idx == 5'd7 && rt_wr_data == {56'd0, mem_word(64'h510) >> 8 == 0 ?
        8'd0 : mem_word(64'h510)[7:0]}, "R9 first result", rt_wr_data,
        {56'd0, mem_word(64'h510)[7:0]});
    @(negedge clk);
    mem_rvalid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req && !busy, "R9 second dropped", {62'd0, mem_req, busy}, 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // R2: base index 0 gives zero base
    do_load("byteD ra0", 6'd34, 10'd0, 5'd0, 5'd0, 5'd9, 64'hDEAD_BEEF, 64'd0,
            16'h0123, 1'b0, 1, 64'h123, 1'b0, 1'b0);
    // R3: negative displacement
    do_load("byteD neg", 6'd34, 10'd0, 5'd3, 5'd0, 5'd4, 64'h1000, 64'd0,
            16'hFFF0, 1'b0, 2, 64'hFF0, 1'b0, 1'b0);
    do_load("halfD", 6'd40, 10'd0, 5'd6, 5'd0, 5'd10, 64'h2200, 64'd0,
            16'h0007, 1'b0, 3, 64'h2207, 1'b1, 1'b0);
    // R3/R5: indexed halfword
    do_load("halfX", 6'd31, 10'd279, 5'd4, 5'd5, 5'd11, 64'h2000, 64'h34,
            16'hFFFF, 1'b0, 1, 64'h2034, 1'b1, 1'b0);
    do_load("halfX ra0 R2", 6'd31, 10'd279, 5'd0, 5'd5, 5'd11, 64'h7777, 64'h4AB,
            16'h0, 1'b0, 2, 64'h4AB, 1'b1, 1'b0);
    do_load("byteX", 6'd31, 10'd87, 5'd8, 5'd9, 5'd12, 64'h3000, 64'h1F,
            16'h0, 1'b0, 1, 64'h301F, 1'b0, 1'b0);
    // R6: update forms
    do_load("byteDU", 6'd35, 10'd0, 5'd5, 5'd0, 5'd6, 64'h4000, 64'd0,
            16'h0041, 1'b0, 2, 64'h4041, 1'b0, 1'b1);
    do_load("halfDU", 6'd41, 10'd0, 5'd13, 5'd0, 5'd14, 64'h4100, 64'd0,
            16'hFFFE, 1'b0, 1, 64'h40FE, 1'b1, 1'b1);
    do_load("byteXU", 6'd31, 10'd119, 5'd15, 5'd16, 5'd17, 64'h5000, 64'h66,
            16'h0, 1'b0, 1, 64'h5066, 1'b0, 1'b1);
    do_load("halfXU", 6'd31, 10'd311, 5'd18, 5'd19, 5'd20, 64'h6000, 64'h2,
            16'h0, 1'b0, 4, 64'h6002, 1'b1, 1'b1);
    // R8: 32-bit mode truncation versus full width
    do_load("wide R8", 6'd34, 10'd0, 5'd3, 5'd0, 5'd4, 64'h1_FFFF_FFF0, 64'd0,
            16'h0020, 1'b0, 1, 64'h2_0000_0010, 1'b0, 1'b0);
    do_load("mode32 R8", 6'd34, 10'd0, 5'd3, 5'd0, 5'd4, 64'h1_FFFF_FFF0, 64'd0,
            16'h0020, 1'b1, 1, 64'h10, 1'b0, 1'b0);
    // R7: illegal update forms
    t_illegal("DU ra0", 6'd35, 10'd0, 5'd0, 5'd4);
    t_illegal("DU ra=rt", 6'd41, 10'd0, 5'd7, 5'd7);
    t_illegal("XU ra=rt", 6'd31, 10'd311, 5'd9, 5'd9);
    t_illegal("XU ra0", 6'd31, 10'd119, 5'd0, 5'd3);
    // R1: unknown codes
    t_unknown("prim36", 6'd36, 10'd0);
    t_unknown("ext88", 6'd31, 10'd88);
    // R9: issue while busy ignored
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule